// File: doc/BRIEF.md
# SPI Frame CRC Generator and Checker

This block sits next to an SPI shift engine and protects its traffic with a cyclic redundancy check. The shift engine reports every bit it sends and every bit it samples through strobes. The block folds each reported bit into its own accumulator, one for the transmit direction and one for the receive direction. The generator polynomial comes from a writable register. The CRC width follows the frame size: 8 bits for byte frames and 16 bits for halfword frames.

Software arms a send-CRC-next flag before the final data frame of a message completes. When that frame ends, the block enters a CRC phase and tells the shift engine to send the transmit accumulator as one extra frame. During that frame both accumulators are frozen and the incoming bits are collected. When the frame ends, the collected value is compared with the receive accumulator, and a mismatch raises a sticky error flag. The armed flag then clears itself.

Dropping the CRC enable clears both accumulators and abandons any pending CRC phase. An off-then-on toggle of the enable is therefore how the two ends of the link are brought back into step.

Top module: `spi_crc_unit`

## Requirements
- R1: After reset the polynomial register reads 0x0007, both accumulators read 0, the error flag, the armed flag and the CRC-phase output are all 0.
- R2: A write to the polynomial register shows on `poly_q` in the next cycle. In 8-bit mode only the low 8 bits of the polynomial take part in the CRC.
- R3: With CRC enabled and outside the CRC phase, each `tx_stb` updates the transmit accumulator. The update is a left shift by one, followed by an XOR with the polynomial when (accumulator MSB XOR `tx_bit`) is 1. The MSB is bit 15 in 16-bit mode and bit 7 in 8-bit mode.
- R4: The receive accumulator applies the same rule to `rx_stb` and `rx_bit`, and is independent of the transmit side.
- R5: In 8-bit mode (`frame16`=0), bits 15..8 of both accumulators stay 0.
- R6: While `crc_en` is 0, both accumulators are held at 0 and strobes have no effect. After re-enable, accumulation restarts from 0.
- R7: A `frame_done` pulse while the armed flag is 1 sets `crc_phase` in the next cycle. While `crc_phase` is 1, neither accumulator changes.
- R8: The `frame_done` pulse that ends the CRC frame clears `crc_phase` and the armed flag.
- R9: At the end of the CRC frame, the received bits (MSB first, CRC-width bits) are compared with the receive accumulator. A mismatch sets `crc_err` and a match leaves it unchanged.
- R10: `err_clr` clears `crc_err`. If a mismatch and `err_clr` occur in the same cycle, the flag is set.
- R11: A `frame_done` pulse while the armed flag is 0 leaves `crc_phase` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crc_en | input | 1 | CRC enable; low clears the accumulators |
| frame16 | input | 1 | 1 selects 16-bit frames/CRC, 0 selects 8-bit |
| poly_wr | input | 1 | Polynomial register write strobe |
| poly_wdata | input | 16 | Polynomial write data |
| crc_next_set | input | 1 | Arms send-CRC-next |
| err_clr | input | 1 | Clears the error flag |
| tx_stb | input | 1 | A transmit bit was shifted out |
| tx_bit | input | 1 | Value of the transmitted bit |
| rx_stb | input | 1 | A receive bit was sampled |
| rx_bit | input | 1 | Value of the received bit |
| frame_done | input | 1 | Last bit of the current frame is being shifted |
| poly_q | output | 16 | Polynomial register |
| tx_crc_q | output | 16 | Transmit accumulator |
| rx_crc_q | output | 16 | Receive accumulator |
| crc_next_q | output | 1 | Armed flag |
| crc_phase | output | 1 | Current frame is the CRC frame (engine sends `tx_crc_q`) |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The accumulators are fed byte frames under the default polynomial and halfword frames under 0x1021. Different transmit and receive data are used so that crossed or shared accumulators show up. An 8-bit run with 0x1107 must match the 0x07 result, which separates proper truncation from use of the full register. CRC frames carrying the exact receive CRC, and then one flipped bit, separate the compare from a stuck flag. Frame ends with and without arming, and a clear that collides with a mismatch, exercise the phase and flag priorities.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
   typedef enum logic {
      PH_DATA = 1'b0,
      PH_CRC  = 1'b1
   } crc_phase_e;
endpackage

// File: rtl/spi_crc_accum.sv
// One bit-serial CRC accumulator with selectable narrow/wide width.
module spi_crc_accum #(
   parameter int CRC_W    = 16,
   parameter int NARROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             bit_in,
   input  logic             wide,
   input  logic [CRC_W-1:0] poly,
   output logic [CRC_W-1:0] acc_q
);
   localparam logic [CRC_W-1:0] NARROW_MASK =
      {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic             msb;
   logic             fb;
   logic [CRC_W-1:0] shifted;
   logic [CRC_W-1:0] acc_nx;

   always_comb begin
      msb     = wide ? acc_q[CRC_W-1] : acc_q[NARROW_W-1];
      fb      = msb ^ bit_in;
      shifted = {acc_q[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      acc_nx  = wide ? shifted : (shifted & NARROW_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else if (step)  acc_q <= acc_nx;
   end
endmodule

// File: rtl/spi_crc_ctrl.sv
// Phase sequencing, CRC frame capture and compare, error flag.
module spi_crc_ctrl
   import spi_crc_pkg::*;
#(
   parameter int CRC_W    = 16,
   parameter int NARROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             crc_en,
   input  logic             wide,
   input  logic             next_set,
   input  logic             err_clr,
   input  logic             rx_stb,
   input  logic             rx_bit,
   input  logic             frame_done,
   input  logic [CRC_W-1:0] rx_crc,
   output crc_phase_e       phase_q,
   output logic             next_q,
   output logic             err_q
);
   localparam logic [CRC_W-1:0] NARROW_MASK =
      {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic [CRC_W-1:0] cap_q;
   logic [CRC_W-1:0] cap_nx;
   logic [CRC_W-1:0] cmp_mask;
   logic             crc_end;
   logic             mismatch;

   always_comb begin
      cmp_mask = wide ? '1 : NARROW_MASK;
      cap_nx   = rx_stb ? {cap_q[CRC_W-2:0], rx_bit} : cap_q;
      crc_end  = crc_en && (phase_q == PH_CRC) && frame_done;
      mismatch = ((cap_nx ^ rx_crc) & cmp_mask) != '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_DATA;
         next_q  <= 1'b0;
         cap_q   <= '0;
      end else if (!crc_en) begin
         phase_q <= PH_DATA;
         next_q  <= 1'b0;
         cap_q   <= '0;
      end else begin
         if (phase_q == PH_CRC) begin
            cap_q <= cap_nx;
            if (frame_done) begin
               phase_q <= PH_DATA;
               next_q  <= 1'b0;
            end
         end else if (frame_done && next_q) begin
            phase_q <= PH_CRC;
            cap_q   <= '0;
         end
         if (next_set) next_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  err_q <= 1'b0;
      else if (crc_end && mismatch) err_q <= 1'b1;
      else if (err_clr)            err_q <= 1'b0;
   end
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit
   import spi_crc_pkg::*;
#(
   parameter int          CRC_W      = 16,
   parameter int          NARROW_W   = 8,
   parameter logic [15:0] POLY_RESET = 16'h0007
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             crc_en,
   input  logic             frame16,
   input  logic             poly_wr,
   input  logic [CRC_W-1:0] poly_wdata,
   input  logic             crc_next_set,
   input  logic             err_clr,
   input  logic             tx_stb,
   input  logic             tx_bit,
   input  logic             rx_stb,
   input  logic             rx_bit,
   input  logic             frame_done,
   output logic [CRC_W-1:0] poly_q,
   output logic [CRC_W-1:0] tx_crc_q,
   output logic [CRC_W-1:0] rx_crc_q,
   output logic             crc_next_q,
   output logic             crc_phase,
   output logic             crc_err
);
   localparam int NUM_DIR = 2;

   generate
      if (NARROW_W < 2 || NARROW_W >= CRC_W) begin : g_bad_width
         $error("spi_crc_unit: NARROW_W must be in 2..CRC_W-1");
      end
   endgenerate

   crc_phase_e         phase;
   logic [NUM_DIR-1:0] stb_v;
   logic [NUM_DIR-1:0] bit_v;
   logic [CRC_W-1:0]   acc_v [NUM_DIR];
   logic               acc_clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       poly_q <= CRC_W'(POLY_RESET);
      else if (poly_wr) poly_q <= poly_wdata;
   end

   assign acc_clear = !crc_en;
   assign stb_v     = {rx_stb, tx_stb};
   assign bit_v     = {rx_bit, tx_bit};

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      spi_crc_accum #(.CRC_W(CRC_W), .NARROW_W(NARROW_W)) i_accum (
         .clk    (clk),
         .rst_n  (rst_n),
         .clear  (acc_clear),
         .step   (stb_v[d] && (phase == PH_DATA)),
         .bit_in (bit_v[d]),
         .wide   (frame16),
         .poly   (poly_q),
         .acc_q  (acc_v[d])
      );
   end

   assign tx_crc_q = acc_v[0];
   assign rx_crc_q = acc_v[1];

   spi_crc_ctrl #(.CRC_W(CRC_W), .NARROW_W(NARROW_W)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .crc_en     (crc_en),
      .wide       (frame16),
      .next_set   (crc_next_set),
      .err_clr    (err_clr),
      .rx_stb     (rx_stb),
      .rx_bit     (rx_bit),
      .frame_done (frame_done),
      .rx_crc     (acc_v[1]),
      .phase_q    (phase),
      .next_q     (crc_next_q),
      .err_q      (crc_err)
   );

   assign crc_phase = (phase == PH_CRC);
endmodule

// File: rtl/spi_crc_unit_chk.sv
module spi_crc_unit_chk #(
   parameter int CRC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             crc_en,
   input logic             frame_done,
   input logic             err_clr,
   input logic [CRC_W-1:0] tx_crc_q,
   input logic [CRC_W-1:0] rx_crc_q,
   input logic             crc_next_q,
   input logic             crc_phase,
   input logic             crc_err
);
   p_clear_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !crc_en |=> (tx_crc_q == '0) && (rx_crc_q == '0));

   p_frozen_in_crc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_en && crc_phase) |=> $stable(tx_crc_q) && $stable(rx_crc_q));

   p_enter_crc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_phase) |-> $past(crc_next_q && frame_done && crc_en));

   p_next_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(crc_next_q) |-> $past((crc_phase && frame_done) || !crc_en));

   p_err_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_err) |-> $past(crc_phase && frame_done && crc_en));

   p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !(crc_phase && frame_done && crc_en)) |=> !crc_err);
endmodule

bind spi_crc_unit spi_crc_unit_chk #(.CRC_W(CRC_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .crc_en     (crc_en),
   .frame_done (frame_done),
   .err_clr    (err_clr),
   .tx_crc_q   (tx_crc_q),
   .rx_crc_q   (rx_crc_q),
   .crc_next_q (crc_next_q),
   .crc_phase  (crc_phase),
   .crc_err    (crc_err)
);

// File: tb/test_spi_crc_unit.sv
`timescale 1ns/1ps
module test_spi_crc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        crc_en = 1'b0, frame16 = 1'b0, poly_wr = 1'b0;
   logic [15:0] poly_wdata = '0;
   logic        crc_next_set = 1'b0, err_clr = 1'b0;
   logic        tx_stb = 1'b0, tx_bit = 1'b0, rx_stb = 1'b0, rx_bit = 1'b0;
   logic        frame_done = 1'b0;
   logic [15:0] poly_q, tx_crc_q, rx_crc_q;
   logic        crc_next_q, crc_phase, crc_err;

   int n_chk = 0, n_bad = 0;
   logic [15:0] ref_tx = '0, ref_rx = '0, ref_poly = 16'h0007;

   always #10 clk = ~clk;

   spi_crc_unit i_spi_crc_unit (.*);

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] step(input logic [15:0] acc, input logic b,
                                        input logic [15:0] p, input logic w16);
      logic [15:0] m;
      logic        fb;
      m  = w16 ? 16'hFFFF : 16'h00FF;
      fb = (w16 ? acc[15] : acc[7]) ^ b;
      return ((acc << 1) ^ (fb ? p : 16'h0)) & m;
   endfunction

   // Shift one frame MSB first; frame_done rides the last bit.
   // upd=1 folds the bits into the bench model (data frames).
   task automatic send_frame(input logic [15:0] td, input logic [15:0] rd,
                             input bit upd, input bit clr_last);
      int nb;
      nb = frame16 ? 16 : 8;
      for (int i = nb - 1; i >= 0; i--) begin
         @(negedge clk);
         tx_stb = 1'b1; rx_stb = 1'b1;
         tx_bit = td[i]; rx_bit = rd[i];
         frame_done = (i == 0);
         err_clr = clr_last && (i == 0);
         if (upd && crc_en) begin
            ref_tx = step(ref_tx, td[i], ref_poly, frame16);
            ref_rx = step(ref_rx, rd[i], ref_poly, frame16);
         end
      end
      @(negedge clk);
      tx_stb = 1'b0; rx_stb = 1'b0; frame_done = 1'b0; err_clr = 1'b0;
   endtask

   task automatic write_poly(input logic [15:0] p);
      @(negedge clk); poly_wr = 1'b1; poly_wdata = p;
      @(negedge clk); poly_wr = 1'b0;
      ref_poly = frame16 ? p : (p & 16'h00FF);
   endtask

   task automatic arm();
      @(negedge clk); crc_next_set = 1'b1;
      @(negedge clk); crc_next_set = 1'b0;
   endtask

   task automatic reenable();
      @(negedge clk); crc_en = 1'b0;
      @(negedge clk); crc_en = 1'b1;
      ref_tx = '0; ref_rx = '0;
   endtask

   task automatic t_reset();
      chk("R1 poly", poly_q, 16'h0007);
      chk("R1 tx", tx_crc_q, 16'h0);
      chk("R1 rx", rx_crc_q, 16'h0);
      chk("R1 flags", {13'd0, crc_err, crc_next_q, crc_phase}, 16'h0);
   endtask

   task automatic t_byte_default();
      crc_en = 1'b1; frame16 = 1'b0;
      send_frame(16'h00A5, 16'h003C, 1'b1, 1'b0);
      chk("R3 tx byte", tx_crc_q, ref_tx);
      chk("R4 rx byte", rx_crc_q, ref_rx);
      send_frame(16'h00FF, 16'h0001, 1'b1, 1'b0);
      chk("R3 tx byte2", tx_crc_q, ref_tx);
      chk("R4 rx byte2", rx_crc_q, ref_rx);
      chk("R11 no arm phase", {15'd0, crc_phase}, 16'h0);
   endtask

   task automatic t_half_poly();
      frame16 = 1'b1;
      write_poly(16'h1021);
      chk("R2 poly readback", poly_q, 16'h1021);
      reenable();
      send_frame(16'h1234, 16'hBEEF, 1'b1, 1'b0);
      chk("R3 tx half", tx_crc_q, ref_tx);
      chk("R4 rx half", rx_crc_q, ref_rx);
   endtask

   task automatic t_truncate();
      logic [15:0] exp_tx;
      frame16 = 1'b0;
      write_poly(16'h1107);
      reenable();
      exp_tx = '0;
      for (int i = 7; i >= 0; i--) exp_tx = step(exp_tx, 1'(8'hC3 >> i), 16'h0007, 1'b0);
      send_frame(16'h00C3, 16'h0081, 1'b1, 1'b0);
      chk("R2 narrow poly truncation", tx_crc_q, exp_tx);
      chk("R5 tx upper zero", {8'd0, tx_crc_q[15:8]}, 16'h0);
      chk("R5 rx upper zero", {8'd0, rx_crc_q[15:8]}, 16'h0);
   endtask

   task automatic t_disable();
      @(negedge clk); crc_en = 1'b0;
      send_frame(16'h00F0, 16'h000F, 1'b0, 1'b0);
      chk("R6 tx held", tx_crc_q, 16'h0);
      chk("R6 rx held", rx_crc_q, 16'h0);
      @(negedge clk); crc_en = 1'b1;
      ref_tx = '0; ref_rx = '0;
      send_frame(16'h0055, 16'h00AA, 1'b1, 1'b0);
      chk("R6 fresh restart", tx_crc_q, ref_tx);
   endtask

   task automatic t_crc_match();
      logic [15:0] hold_tx, hold_rx;
      arm();
      chk("R7 armed", {15'd0, crc_next_q}, 16'h1);
      send_frame(16'h0011, 16'h0022, 1'b1, 1'b0);
      chk("R7 phase entered", {15'd0, crc_phase}, 16'h1);
      hold_tx = ref_tx; hold_rx = ref_rx;
      send_frame(hold_tx, hold_rx, 1'b0, 1'b0);
      chk("R7 tx frozen", tx_crc_q, hold_tx);
      chk("R7 rx frozen", rx_crc_q, hold_rx);
      chk("R8 phase left", {15'd0, crc_phase}, 16'h0);
      chk("R8 flag cleared", {15'd0, crc_next_q}, 16'h0);
      chk("R9 match no error", {15'd0, crc_err}, 16'h0);
   endtask

   task automatic t_crc_mismatch();
      arm();
      send_frame(16'h0077, 16'h0099, 1'b1, 1'b0);
      send_frame(ref_tx, ref_rx ^ 16'h0001, 1'b0, 1'b0);
      chk("R9 mismatch error", {15'd0, crc_err}, 16'h1);
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk("R10 cleared", {15'd0, crc_err}, 16'h0);
      arm();
      send_frame(16'h0042, 16'h0024, 1'b1, 1'b0);
      send_frame(ref_tx, ref_rx ^ 16'h0080, 1'b0, 1'b1);
      chk("R10 set beats clear", {15'd0, crc_err}, 16'h1);
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte_default();
      t_half_poly();
      t_truncate();
      t_disable();
      t_crc_match();
      t_crc_mismatch();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule